// File: doc/BRIEF.md
# Repeat-Mode Converter Channel Sequencer

This block is the digital control front end of an eight-input sampling converter. A host talks to it over a 16-clock serial frame framed by an active-low select. Each frame carries an optional configuration word, made of a channel mask, a repeat flag and a write-enable flag. At the same time the frame returns the result of an earlier conversion. The block launches one conversion per frame on an external converter core. It drives a start pulse and a channel index, then holds the core's 10-bit reply until the next frame shifts it out.

In repeat mode the block walks the enabled inputs from low to high and wraps back to the lowest one, with no further host writes. Any accepted configuration write restarts that walk. With repeat off, every frame converts the lowest enabled input. All serial pins are sampled in the system clock domain. The select falling edge opens a frame, and the rising edge closes it. A frame that does not hold exactly 16 serial clocks is thrown away.

Top module: `adc_seq_top`

## Requirements
- R1: A frame is the span with `spi_cs_n` low. MOSI is sampled on each rising `spi_sclk` edge, MSB first. MISO shows frame bit 15 from the select falling edge onward and moves to the next lower bit after each falling `spi_sclk` edge. MISO is 0 while the select is high.
- R2: Incoming word layout: bit 15 enables the write, bit 14 is the repeat flag, and bit (13 - i) enables input i for i = 0..7. Bits 5..0 are ignored. A completed frame with bit 15 at 0 leaves the mask and the repeat flag unchanged.
- R3: At the start of every frame, `conv_start` pulses exactly once for one clock, with `conv_chan` giving the input to convert. If the mask is all zeros, no pulse is issued.
- R4: With the repeat flag set, consecutive frames convert the enabled inputs in ascending index order. After the highest enabled input, the sequence wraps to the lowest enabled one.
- R5: Any accepted write, including one that leaves the mask the same, makes the next frame convert the lowest enabled input.
- R6: The word shifted out in a frame reports the conversion launched at the start of the previous completed frame. Its layout is input index in bits 15..12, zeros in bits 11..10 and the 10-bit result in bits 9..0.
- R7: An accepted write discards the conversion launched in the frame that carried it. The following frame then outputs all zeros. The output word is all zeros whenever no valid result is held.
- R8: With the repeat flag clear, every frame converts the lowest enabled input.
- R9: A frame that ends with any count other than exactly 16 rising serial clocks is discarded. The mask, the repeat flag, the walk position and the held result all stay as they were before that frame.
- R10: After reset, the mask is empty and repeat is off. No start pulse is issued, MISO is 0, and the first frame outputs zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| conv_start | output | 1 | One-clock pulse that launches a conversion |
| conv_chan | output | 3 | Input index for the launched conversion |
| conv_done | input | 1 | Converter core reply strobe |
| conv_data | input | 10 | Converter core result, valid with `conv_done` |

## Verification
The select pins pass through a two-stage synchronizer and an edge register before any decision is made. The start pulse therefore appears a few system clocks after the select falls, and the bench counts start pulses over the whole frame instead of at one fixed clock. Results follow a one-frame pipeline: each table row gives the word expected in that frame, derived from the frame before it. A write clears the held result, so the frame right after a write expects zeros. MISO bits are sampled half a serial period after each update, well clear of the synchronizer delay.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   // Frame boundary events, each a one-clock pulse in the system domain
   typedef struct packed {
      logic start;    // select fell: a new frame opened
      logic done_ok;  // select rose after exactly one full frame
      logic abort;    // select rose after a short or long frame
   } frame_evt_t;

   // Scan a mask cyclically from index 'from' and return the first set index
   function automatic int unsigned first_set_from(input logic [31:0] mask,
                                                  input int unsigned n,
                                                  input int unsigned from);
      int unsigned r;
      logic        hit;
      r   = 0;
      hit = 1'b0;
      for (int unsigned k = 0; k < 32; k++) begin
         if (k < n && !hit) begin
            if (mask[(from + k) % n]) begin
               r   = (from + k) % n;
               hit = 1'b1;
            end
         end
      end
      return r;
   endfunction

endpackage

// File: rtl/adc_seq_spi.sv
module adc_seq_spi
   import adc_seq_pkg::*;
#(
   parameter int FRAME_W     = 16,
   parameter int SYNC_STAGES = 2
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sclk,
   input  logic               cs_n,
   input  logic               mosi,
   input  logic [FRAME_W-1:0] tx_word,
   output logic               miso,
   output frame_evt_t         evt,
   output logic [FRAME_W-1:0] rx_word
);
   localparam int CNT_W = $clog2(FRAME_W + 2);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
   localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);
   // bit 2 = sclk, bit 1 = cs_n, bit 0 = mosi
   localparam logic [2:0] PIN_IDLE = 3'b010;

   if (FRAME_W < 8)     begin : g_bad_frame $error("FRAME_W too small"); end
   if (SYNC_STAGES < 0) begin : g_bad_sync  $error("SYNC_STAGES negative"); end

   logic [2:0] pins_raw, pins_s;
   assign pins_raw = {sclk, cs_n, mosi};

   if (SYNC_STAGES == 0) begin : g_nosync
      assign pins_s = pins_raw;
   end else begin : g_sync
      logic [2:0] chain [SYNC_STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int s = 0; s < SYNC_STAGES; s++) chain[s] <= PIN_IDLE;
         end else begin
            chain[0] <= pins_raw;
            for (int s = 1; s < SYNC_STAGES; s++) chain[s] <= chain[s-1];
         end
      end
      assign pins_s = chain[SYNC_STAGES-1];
   end

   logic sclk_s, cs_s, mosi_s, sclk_d, cs_d;
   assign sclk_s = pins_s[2];
   assign cs_s   = pins_s[1];
   assign mosi_s = pins_s[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b0;
         cs_d   <= 1'b1;
      end else begin
         sclk_d <= sclk_s;
         cs_d   <= cs_s;
      end
   end

   logic cs_fall, cs_rise, sck_rise, sck_fall;
   assign cs_fall  =  cs_d & ~cs_s;
   assign cs_rise  = ~cs_d &  cs_s;
   assign sck_rise = ~sclk_d &  sclk_s & ~cs_s;
   assign sck_fall =  sclk_d & ~sclk_s & ~cs_s;

   logic [CNT_W-1:0]   cnt_q;
   logic [FRAME_W-1:0] rx_q, tx_q;
   frame_evt_t         evt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         rx_q  <= '0;
         tx_q  <= '0;
         evt_q <= '0;
      end else begin
         evt_q.start   <= cs_fall;
         evt_q.done_ok <= cs_rise && (cnt_q == CNT_FULL);
         evt_q.abort   <= cs_rise && (cnt_q != CNT_FULL);
         if (cs_fall) begin
            cnt_q <= '0;
            tx_q  <= tx_word;
         end else begin
            if (sck_rise) begin
               rx_q <= {rx_q[FRAME_W-2:0], mosi_s};
               if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
            end
            if (sck_fall && cnt_q != '0) tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
         end
      end
   end

   assign miso    = ~cs_s & tx_q[FRAME_W-1];
   assign evt     = evt_q;
   assign rx_word = rx_q;

   // R9: a closing pulse is either complete or aborted, never both
   a_r9_close_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(evt_q.done_ok && evt_q.abort));
   // R1: the bit counter never runs past its saturation value
   a_r1_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      sck_rise |=> cnt_q <= CNT_SAT);

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
   parameter int FRAME_W = 16,
   parameter int NUM_CH  = 8
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frame_done,
   input  logic               frame_abort,
   input  logic [FRAME_W-1:0] rx_word,
   output logic [NUM_CH-1:0]  mask,
   output logic               repeat_en,
   output logic               wr_accept
);
   localparam int WR_BIT   = FRAME_W - 1;
   localparam int RP_BIT   = FRAME_W - 2;
   localparam int MASK_TOP = FRAME_W - 3;
   localparam int RSV_W    = FRAME_W - 2 - NUM_CH;

   if (RSV_W < 0) begin : g_bad_fit $error("mask does not fit in frame"); end

   logic [NUM_CH-1:0] mask_in;
   for (genvar i = 0; i < NUM_CH; i++) begin : g_mask_bit
      assign mask_in[i] = rx_word[MASK_TOP - i];
   end

   if (RSV_W > 0) begin : g_rsv
      logic unused_rsvd;
      assign unused_rsvd = ^rx_word[RSV_W-1:0];
   end

   logic [NUM_CH-1:0] mask_q;
   logic              rep_q;

   assign wr_accept = frame_done & rx_word[WR_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         rep_q  <= 1'b0;
      end else if (wr_accept) begin
         mask_q <= mask_in;
         rep_q  <= rx_word[RP_BIT];
      end
   end

   assign mask      = mask_q;
   assign repeat_en = rep_q;

   // R9: an aborted frame leaves the register untouched
   a_r9_abort_keeps_cfg: assert property (@(posedge clk) disable iff (!rst_n)
      frame_abort |=> $stable(mask_q) && $stable(rep_q));
   // R2: a complete frame without the write flag changes nothing
   a_r2_nowrite_keeps_cfg: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && !rx_word[WR_BIT]) |=> $stable(mask_q) && $stable(rep_q));

endmodule

// File: rtl/adc_seq_pick.sv
module adc_seq_pick
   import adc_seq_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int CH_W   = $clog2(NUM_CH)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              frame_done,
   input  logic              wr_accept,
   input  logic [NUM_CH-1:0] mask,
   input  logic              repeat_en,
   output logic              conv_start,
   output logic [CH_W-1:0]   conv_chan,
   output logic [CH_W-1:0]   infl_chan,
   output logic              infl_launched
);
   if (NUM_CH < 2 || NUM_CH > 32) begin : g_bad_ch $error("NUM_CH out of range"); end

   logic [CH_W-1:0] last_q, chan_d;
   logic            restart_q;
   logic            start_q, launched_q;
   logic [CH_W-1:0] chan_q;
   logic [31:0]     mask_w;

   assign mask_w = 32'(mask);

   always_comb begin
      if (restart_q || !repeat_en)
         chan_d = CH_W'(first_set_from(mask_w, NUM_CH, 0));
      else
         chan_d = CH_W'(first_set_from(mask_w, NUM_CH,
                                       (int'(last_q) + 1) % NUM_CH));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_q     <= '0;
         restart_q  <= 1'b1;
         start_q    <= 1'b0;
         launched_q <= 1'b0;
         chan_q     <= '0;
      end else begin
         start_q <= 1'b0;
         if (frame_start) begin
            launched_q <= |mask;
            if (|mask) begin
               start_q <= 1'b1;
               chan_q  <= chan_d;
            end
         end
         if (frame_done) begin
            if (wr_accept) begin
               restart_q <= 1'b1;
            end else if (launched_q) begin
               last_q    <= chan_q;
               restart_q <= 1'b0;
            end
         end
      end
   end

   assign conv_start    = start_q;
   assign conv_chan     = chan_q;
   assign infl_chan     = chan_q;
   assign infl_launched = launched_q;

   // R3: a start pulse only follows a frame opening
   a_r3_start_on_open: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> $past(frame_start));
   // R3: never launch with an empty mask
   a_r3_no_empty_start: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> (mask != '0));
   // R4: the launched input is always an enabled one
   a_r4_chan_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> mask[conv_chan]);
   // R5: an accepted write arms the restart of the walk
   a_r5_write_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      wr_accept |=> restart_q);

endmodule

// File: rtl/adc_seq_result.sv
module adc_seq_result #(
   parameter int FRAME_W = 16,
   parameter int RES_W   = 10,
   parameter int CH_W    = 3
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frame_start,
   input  logic               frame_done,
   input  logic               frame_abort,
   input  logic               wr_accept,
   input  logic               infl_launched,
   input  logic [CH_W-1:0]    infl_chan,
   input  logic               conv_done,
   input  logic [RES_W-1:0]   conv_data,
   output logic [FRAME_W-1:0] tx_word
);
   localparam int IDX_W = 4;
   localparam int GAP_W = FRAME_W - IDX_W - RES_W;

   if (GAP_W < 0)     begin : g_bad_res $error("result does not fit"); end
   if (CH_W > IDX_W)  begin : g_bad_idx $error("index field too narrow"); end

   logic             cap_valid_q;
   logic [RES_W-1:0] cap_data_q;
   logic             pend_valid_q;
   logic [RES_W-1:0] pend_data_q;
   logic [CH_W-1:0]  pend_chan_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_valid_q  <= 1'b0;
         cap_data_q   <= '0;
         pend_valid_q <= 1'b0;
         pend_data_q  <= '0;
         pend_chan_q  <= '0;
      end else begin
         if (frame_start) begin
            cap_valid_q <= 1'b0;
         end else if (conv_done && infl_launched && !cap_valid_q) begin
            cap_valid_q <= 1'b1;
            cap_data_q  <= conv_data;
         end
         if (frame_done) begin
            pend_valid_q <= cap_valid_q && !wr_accept;
            pend_data_q  <= cap_data_q;
            pend_chan_q  <= infl_chan;
         end
      end
   end

   if (GAP_W > 0) begin : g_gap
      assign tx_word = pend_valid_q
         ? {IDX_W'(pend_chan_q), {GAP_W{1'b0}}, pend_data_q} : '0;
   end else begin : g_nogap
      assign tx_word = pend_valid_q ? {IDX_W'(pend_chan_q), pend_data_q} : '0;
   end

   // R7: an accepted write drops the result in flight
   a_r7_write_drops: assert property (@(posedge clk) disable iff (!rst_n)
      wr_accept |=> !pend_valid_q);
   // R9: an aborted frame keeps the held result
   a_r9_abort_keeps_res: assert property (@(posedge clk) disable iff (!rst_n)
      frame_abort |=> $stable(pend_valid_q) && $stable(pend_data_q)
                      && $stable(pend_chan_q));
   // R7: no held result means an all-zero outgoing word
   a_r7_zero_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
      !pend_valid_q |-> (tx_word == '0));

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
   import adc_seq_pkg::*;
#(
   parameter int FRAME_W     = 16,
   parameter int NUM_CH      = 8,
   parameter int RES_W       = 10,
   parameter int SYNC_STAGES = 2,
   localparam int CH_W       = $clog2(NUM_CH)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             spi_sclk,
   input  logic             spi_cs_n,
   input  logic             spi_mosi,
   output logic             spi_miso,
   output logic             conv_start,
   output logic [CH_W-1:0]  conv_chan,
   input  logic             conv_done,
   input  logic [RES_W-1:0] conv_data
);
   frame_evt_t         evt;
   logic [FRAME_W-1:0] rx_word, tx_word;
   logic [NUM_CH-1:0]  mask;
   logic               repeat_en, wr_accept, infl_launched;
   logic [CH_W-1:0]    infl_chan;

   adc_seq_spi #(.FRAME_W(FRAME_W), .SYNC_STAGES(SYNC_STAGES)) u_spi (
      .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n),
      .mosi(spi_mosi), .tx_word(tx_word), .miso(spi_miso),
      .evt(evt), .rx_word(rx_word));

   adc_seq_ctrl #(.FRAME_W(FRAME_W), .NUM_CH(NUM_CH)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .frame_done(evt.done_ok),
      .frame_abort(evt.abort), .rx_word(rx_word), .mask(mask),
      .repeat_en(repeat_en), .wr_accept(wr_accept));

   adc_seq_pick #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_pick (
      .clk(clk), .rst_n(rst_n), .frame_start(evt.start),
      .frame_done(evt.done_ok), .wr_accept(wr_accept), .mask(mask),
      .repeat_en(repeat_en), .conv_start(conv_start), .conv_chan(conv_chan),
      .infl_chan(infl_chan), .infl_launched(infl_launched));

   adc_seq_result #(.FRAME_W(FRAME_W), .RES_W(RES_W), .CH_W(CH_W)) u_res (
      .clk(clk), .rst_n(rst_n), .frame_start(evt.start),
      .frame_done(evt.done_ok), .frame_abort(evt.abort),
      .wr_accept(wr_accept), .infl_launched(infl_launched),
      .infl_chan(infl_chan), .conv_done(conv_done), .conv_data(conv_data),
      .tx_word(tx_word));

   // R1: MISO stays low while no frame is open
   a_r1_miso_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3))
      |-> !spi_miso);

endmodule

// File: tb/sim_adc_seq_top.sv
module sim_adc_seq_top;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 8;   // system clocks per serial half period
   localparam int NVEC       = 24;

   logic       clk = 1'b0, rst_n = 1'b0;
   logic       sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
   logic       miso, conv_start, conv_done = 1'b0;
   logic [2:0] conv_chan;
   logic [9:0] conv_data = '0;

   int checks = 0, fails = 0, starts = 0;
   logic [2:0] last_chan = '0;
   logic [2:0] rep_chan  = '0;
   int         dly = 0;
   logic       finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   adc_seq_top u0 (
      .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
      .spi_mosi(mosi), .spi_miso(miso), .conv_start(conv_start),
      .conv_chan(conv_chan), .conv_done(conv_done), .conv_data(conv_data));

   function automatic logic [9:0] core_val(input logic [2:0] ch);
      return 10'(int'(ch) * 37 + 5);
   endfunction

   // Converter core model: replies three clocks after each start
   always @(posedge clk) begin
      conv_done <= 1'b0;
      if (conv_start) begin
         starts    <= starts + 1;
         last_chan <= conv_chan;
         rep_chan  <= conv_chan;
         dly       <= 3;
      end else if (dly > 0) begin
         dly <= dly - 1;
         if (dly == 1) begin
            conv_done <= 1'b1;
            conv_data <= core_val(rep_chan);
         end
      end
   end

   // {abort, din, expected dout, expected start, expected chan}
   localparam logic [36:0] VEC [NVEC] = '{
      {1'b0,16'h0000,16'h0000,1'b0,3'd0},  // 1  R10 nothing configured
      {1'b0,16'hF800,16'h0000,1'b0,3'd0},  // 2  R2 write repeat ch0..2
      {1'b0,16'h0000,16'h0000,1'b1,3'd0},  // 3  R5 R7 lowest first, zeros
      {1'b0,16'h0000,16'h0005,1'b1,3'd1},  // 4  R4 R6
      {1'b0,16'h0000,16'h102A,1'b1,3'd2},  // 5  R4
      {1'b0,16'h0000,16'h204F,1'b1,3'd0},  // 6  R4 wrap
      {1'b0,16'h7FFF,16'h0005,1'b1,3'd1},  // 7  R2 write flag low ignored
      {1'b0,16'hF800,16'h102A,1'b1,3'd2},  // 8  R5 same mask rewrite
      {1'b0,16'h0000,16'h0000,1'b1,3'd0},  // 9  R5 R7 restart
      {1'b0,16'h0000,16'h0005,1'b1,3'd1},  // 10
      {1'b1,16'hFFFF,16'h0000,1'b1,3'd2},  // 11 R9 aborted frame
      {1'b0,16'h0000,16'h102A,1'b1,3'd2},  // 12 R9 retried position
      {1'b0,16'h8540,16'h204F,1'b1,3'd0},  // 13 R8 single mode ch3,5,7
      {1'b0,16'h0000,16'h0000,1'b1,3'd3},  // 14 R8
      {1'b0,16'h0000,16'h3074,1'b1,3'd3},  // 15 R8 no advance
      {1'b0,16'h0000,16'h3074,1'b1,3'd3},  // 16 R8
      {1'b0,16'hC540,16'h3074,1'b1,3'd3},  // 17 R4 repeat ch3,5,7
      {1'b0,16'h0000,16'h0000,1'b1,3'd3},  // 18
      {1'b0,16'h0000,16'h3074,1'b1,3'd5},  // 19 R4
      {1'b0,16'h0000,16'h50BE,1'b1,3'd7},  // 20 R4
      {1'b0,16'h0000,16'h7108,1'b1,3'd3},  // 21 R4 wrap
      {1'b0,16'hC000,16'h3074,1'b1,3'd5},  // 22 R3 empty mask write
      {1'b0,16'h0000,16'h0000,1'b0,3'd0},  // 23 R3 no start
      {1'b0,16'h0000,16'h0000,1'b0,3'd0}   // 24 R3 R7
   };

   task automatic check(input string req, input int got, input int exp);
      checks++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   // One host frame of nclk serial clocks; returns the bits read on MISO
   task automatic xfer(input logic [15:0] din, input int nclk,
                       output logic [15:0] dout);
      dout = '0;
      @(negedge clk);
      cs_n = 1'b0;
      for (int i = 0; i < nclk; i++) begin
         mosi = (i < 16) ? din[15 - i] : 1'b0;
         repeat (HALF) @(negedge clk);
         if (i < 16) dout[15 - i] = miso;
         sclk = 1'b1;
         repeat (HALF) @(negedge clk);
         sclk = 1'b0;
      end
      repeat (HALF) @(negedge clk);
      cs_n = 1'b1;
      mosi = 1'b0;
      repeat (4 * HALF) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
   endtask

   initial begin
      int s0;
      logic [15:0] rd;
      do_reset();
      // R10: idle state after reset
      check("R10 miso idle", miso, 0);
      check("R10 no start", starts, 0);

      for (int v = 0; v < NVEC; v++) begin
         logic [36:0] e;
         e  = VEC[v];
         s0 = starts;
         xfer(e[35:20], e[36] ? 5 : 16, rd);
         if (!e[36]) check("R6 output word", rd, e[19:4]);
         check("R3 start count", starts - s0, e[3] ? 1 : 0);
         if (e[3]) check("R4 started input", last_chan, e[2:0]);
      end

      // R10: reset clears a configured block
      do_reset();
      s0 = starts;
      xfer(16'h0000, 16, rd);
      check("R10 first frame zeros", rd, 0);
      check("R10 no start after reset", starts - s0, 0);

      // R9: a 17-clock frame carrying a write is discarded
      xfer(16'hD000, 17, rd);
      s0 = starts;
      xfer(16'h0000, 16, rd);
      check("R9 long frame dropped", starts - s0, 0);

      // R2: bit 12 selects input 1; accepted write then launches it
      xfer(16'hD000, 16, rd);
      s0 = starts;
      xfer(16'h0000, 16, rd);
      check("R2 input1 start", starts - s0, 1);
      check("R2 input1 index", last_chan, 1);
      xfer(16'h0000, 16, rd);
      check("R6 input1 result", rd, 16'h102A);
      check("R1 idle after frame", miso, 0);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule